// File: doc/BRIEF.md
# Utilization-Driven Pipeline Mode Governor

This block decides, from one cycle to the next, whether a core should run on its narrow, energy-saving pipeline (small mode) or on its wide pipeline (big mode). Each mode has its own utilization tracker. A tracker watches the per-cycle retirement count against width fractions and streak lengths that come from a policy table. A core-state directive from the chip power manager selects the row of that table. When a tracker's verdict calls for the other mode, the block does not switch at once. It waits for a cycle in which a demand load miss and a retirement stall coincide, so that the cost of the switch is hidden behind the miss.

A switch has two steps: a pipeline flush, then a memory fence. The governor drives a request for each step and waits for the matching done input. It changes its mode output only after the fence completes. The core-state directive also caps the share of each fixed interval that may be spent in big mode. When that budget runs out, the block forces small mode without waiting for an opportunity. It refuses to re-enter big mode until the next interval begins.

Top module: `pipe_mode_governor`

## Requirements
- R1: After reset, `big_mode`, `switch_busy`, `flush_req` and `fence_req` are all 0 (small mode, no switch in progress).
- R2: In small mode with no switch in progress, the small tracker declares the pipe utilized after a run of consecutive qualifying samples. A sample qualifies when retire*100 >= fraction*3. With `core_state` 3 or 4 (values above 4 count as 4), the fraction is 80% and the run is 8 samples, so `retire_cnt` >= 3. With `core_state` 0..2, the fraction is 50% and the run is 6 samples, so `retire_cnt` >= 2. Any other sample restarts the run. A utilized small tracker makes big mode the wanted mode.
- R3: In big mode, the big tracker makes small mode the wanted mode once it is in its unused state and has seen a run of consecutive low samples. A sample is low when retire*100 <= fraction*4. With `core_state` >= 3, the fraction is 20% and the run is 2, so `retire_cnt` == 0. With `core_state` <= 2, the fraction is 50% and the run is 4, so `retire_cnt` <= 2. Any other sample restarts the run.
- R4: A switch that is not forced starts only in a cycle where the wanted mode differs from the current one and `miss_hint`=1, `stall_hint`=1 and `early_load_hint`=0. `flush_req` rises one cycle later.
- R5: A switch holds `flush_req` until `flush_done`. It then holds `fence_req` until `fence_done`, and `big_mode` toggles in the cycle after `fence_done`. `switch_busy` is high throughout. A `fence_done` that arrives during the flush step is ignored.
- R6: While a switch is in progress, hints and tracker verdicts cannot start another switch, and `big_mode` changes exactly once per switch.
- R7: The tracker of the mode being entered starts in its unused state with empty runs, whatever it held when that mode was last left.
- R8: Over each 64-cycle interval counted from reset, cycles spent in big mode outside a switch never exceed a cap. The cap is 64, 48, 32, 16 or 0 cycles for `core_state` 4, 3, 2, 1 or 0. Using up the cap starts a switch to small mode with no hint needed. Big mode is not re-entered until the next interval.
- R9: With `core_state` 0, the block never leaves small mode.
- R10: With `core_state` 4 and a utilized big pipe (`retire_cnt` = 4), the block never leaves big mode, even across interval boundaries and with hints present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| retire_cnt | input | RET_W (3) | Instructions retired this cycle |
| core_state | input | CS_W (3) | Core-state directive from the power manager, 0..4 |
| miss_hint | input | 1 | A demand load missed the cache recently |
| stall_hint | input | 1 | Retirement is stalled this cycle |
| early_load_hint | input | 1 | An outstanding load is about to complete |
| flush_done | input | 1 | The pipeline flush has finished |
| fence_done | input | 1 | The memory fence has finished |
| big_mode | output | 1 | 1 = wide pipeline active, 0 = narrow pipeline active |
| switch_busy | output | 1 | A mode switch is in progress |
| flush_req | output | 1 | Request to flush the active pipeline |
| fence_req | output | 1 | Request to fence memory after the flush |

## Verification
The residency budget and the small-mode tracker's demand for big mode can act in the same cycle. The bench provokes this by using up a 16-cycle cap in big mode and returning to small mode while `retire_cnt` and both hints stay high for the rest of the interval. The small tracker therefore turns utilized long before the interval ends. The bench judges that `flush_req` stays low on every cycle through the interval-wrap edge and rises on exactly the next one. The first leg of that run also checks that the forced exit leaves exactly 16 counted big-mode cycles.

// File: rtl/pmg_pkg.sv
`timescale 1ns/1ps
package pmg_pkg;
    localparam int PCT_W    = 7;
    localparam int STREAK_W = 4;
    localparam int LANE_SMALL = 0;
    localparam int LANE_BIG   = 1;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FLUSH = 2'd1,
        SEQ_FENCE = 2'd2
    } seq_e;

    typedef struct packed {
        logic [PCT_W-1:0]    busy_pct;
        logic [PCT_W-1:0]    quiet_pct;
        logic [STREAK_W-1:0] busy_need;
        logic [STREAK_W-1:0] quiet_need;
    } trk_cfg_t;
endpackage

// File: rtl/pmg_policy.sv
`timescale 1ns/1ps
module pmg_policy
    import pmg_pkg::*;
#(
    parameter int CS_W     = 3,
    parameter int INTERVAL = 64,
    parameter int CAP_W    = 7
) (
    input  logic [CS_W-1:0]  core_state,
    output trk_cfg_t         cfg_small,
    output trk_cfg_t         cfg_big,
    output logic [CAP_W-1:0] cap,
    output logic             cap_full
);
    localparam int TOP_LEVEL = 4;

    logic [2:0] level;
    logic       perf;

    always_comb begin
        level = (int'(core_state) > TOP_LEVEL) ? 3'(TOP_LEVEL) : 3'(core_state);
        perf  = (level > 3'd2);
        if (perf) begin
            cfg_small.busy_pct   = PCT_W'(80);
            cfg_small.quiet_pct  = PCT_W'(20);
            cfg_small.busy_need  = STREAK_W'(8);
            cfg_small.quiet_need = STREAK_W'(4);
            cfg_big.busy_pct     = PCT_W'(80);
            cfg_big.quiet_pct    = PCT_W'(20);
            cfg_big.busy_need    = STREAK_W'(6);
            cfg_big.quiet_need   = STREAK_W'(2);
        end else begin
            cfg_small.busy_pct   = PCT_W'(50);
            cfg_small.quiet_pct  = PCT_W'(20);
            cfg_small.busy_need  = STREAK_W'(6);
            cfg_small.quiet_need = STREAK_W'(2);
            cfg_big.busy_pct     = PCT_W'(80);
            cfg_big.quiet_pct    = PCT_W'(50);
            cfg_big.busy_need    = STREAK_W'(8);
            cfg_big.quiet_need   = STREAK_W'(4);
        end
        cap      = CAP_W'((INTERVAL * int'(level)) / TOP_LEVEL);
        cap_full = (int'(level) == TOP_LEVEL);
    end
endmodule

// File: rtl/pmg_tracker.sv
`timescale 1ns/1ps
module pmg_tracker
    import pmg_pkg::*;
#(
    parameter int LANES = 3,
    parameter int RET_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             clear,
    input  logic [RET_W-1:0] retire,
    input  trk_cfg_t         cfg,
    output logic             utilized,
    output logic             quiet
);
    localparam int PROD_W = RET_W + PCT_W + $clog2(LANES + 1) + 1;

    typedef struct packed {
        logic                util;
        logic [STREAK_W-1:0] hi;
        logic [STREAK_W-1:0] lo;
    } trk_st_t;

    trk_st_t             st_q, st_d;
    logic [PROD_W-1:0]   scaled, busy_lim, quiet_lim;
    logic                hit_busy, hit_quiet;
    logic [STREAK_W-1:0] hi_n, lo_n;

    function automatic logic [STREAK_W-1:0] sat_inc(input logic [STREAK_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    always_comb begin
        scaled    = PROD_W'(retire) * PROD_W'(100);
        busy_lim  = PROD_W'(cfg.busy_pct) * PROD_W'(LANES);
        quiet_lim = PROD_W'(cfg.quiet_pct) * PROD_W'(LANES);
        hit_busy  = (scaled >= busy_lim);
        hit_quiet = (scaled <= quiet_lim);
        hi_n      = hit_busy  ? sat_inc(st_q.hi) : '0;
        lo_n      = hit_quiet ? sat_inc(st_q.lo) : '0;
        st_d      = st_q;
        if (clear) begin
            st_d = '0;
        end else if (sample_en) begin
            st_d.hi = hi_n;
            st_d.lo = lo_n;
            if (!st_q.util && hi_n >= cfg.busy_need) begin
                st_d.util = 1'b1;
            end else if (st_q.util && lo_n >= cfg.quiet_need) begin
                st_d.util = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign utilized = st_q.util;
    assign quiet    = !st_q.util && (st_q.lo >= cfg.quiet_need);

    // R2: the utilized verdict is only reached on a sampled busy cycle
    a_r2_promote_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(utilized) |-> $past(sample_en && hit_busy && !clear));

    // R7: entering a mode leaves its tracker unused with an empty low run
    a_r7_clear_unused: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!utilized && !quiet));
endmodule

// File: rtl/pmg_residency.sv
`timescale 1ns/1ps
module pmg_residency #(
    parameter int INTERVAL = 64,
    parameter int CAP_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic [CAP_W-1:0] cap,
    input  logic             cap_full,
    output logic             leave_big,
    output logic             deny_big
);
    typedef struct packed {
        logic [CAP_W-1:0] tick;
        logic [CAP_W-1:0] used;
    } res_st_t;

    res_st_t st_q, st_d;
    logic    wrap;

    always_comb begin
        wrap = (st_q.tick == CAP_W'(INTERVAL - 1));
        st_d = st_q;
        if (wrap) begin
            st_d.tick = '0;
            st_d.used = '0;
        end else begin
            st_d.tick = st_q.tick + 1'b1;
            if (count_en && st_q.used < cap) st_d.used = st_q.used + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign leave_big = !cap_full && (({1'b0, st_q.used} + 1'b1) >= {1'b0, cap});
    assign deny_big  = (st_q.used >= cap);

    // R8: the budget count never climbs past the cap inside an interval
    a_r8_hold_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.used >= cap && !wrap) |=> (st_q.used == $past(st_q.used)));

    // R8: every interval starts with an empty budget count
    a_r8_interval_restart: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (st_q.used == '0));
endmodule

// File: rtl/pipe_mode_governor.sv
`timescale 1ns/1ps
module pipe_mode_governor
    import pmg_pkg::*;
#(
    parameter int RET_W       = 3,
    parameter int CS_W        = 3,
    parameter int SMALL_WIDTH = 3,
    parameter int BIG_WIDTH   = 4,
    parameter int INTERVAL    = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RET_W-1:0] retire_cnt,
    input  logic [CS_W-1:0]  core_state,
    input  logic             miss_hint,
    input  logic             stall_hint,
    input  logic             early_load_hint,
    input  logic             flush_done,
    input  logic             fence_done,
    output logic             big_mode,
    output logic             switch_busy,
    output logic             flush_req,
    output logic             fence_req
);
    localparam int CAP_W  = $clog2(INTERVAL + 1);
    localparam int NLANES = 2;

    typedef struct packed {
        seq_e seq;
        logic big;
    } gov_st_t;

    gov_st_t            st_q, st_d;
    trk_cfg_t           cfg_small, cfg_big;
    trk_cfg_t           lane_cfg [NLANES];
    logic [CAP_W-1:0]   cap;
    logic               cap_full, leave_big, deny_big;
    logic [NLANES-1:0]  lane_sample, lane_clear, lane_util, lane_quiet;
    logic               hint_ok, want_other, force_out, commit, in_idle;

    pmg_policy #(.CS_W(CS_W), .INTERVAL(INTERVAL), .CAP_W(CAP_W)) u_policy (
        .core_state (core_state),
        .cfg_small  (cfg_small),
        .cfg_big    (cfg_big),
        .cap        (cap),
        .cap_full   (cap_full)
    );

    assign lane_cfg[LANE_SMALL] = cfg_small;
    assign lane_cfg[LANE_BIG]   = cfg_big;

    assign in_idle = (st_q.seq == SEQ_IDLE);
    assign commit  = (st_q.seq == SEQ_FENCE) && fence_done;

    assign lane_sample[LANE_SMALL] = in_idle && !st_q.big;
    assign lane_sample[LANE_BIG]   = in_idle &&  st_q.big;
    assign lane_clear[LANE_SMALL]  = commit &&  st_q.big;
    assign lane_clear[LANE_BIG]    = commit && !st_q.big;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        localparam int W = (g == LANE_SMALL) ? SMALL_WIDTH : BIG_WIDTH;
        pmg_tracker #(.LANES(W), .RET_W(RET_W)) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .sample_en (lane_sample[g]),
            .clear     (lane_clear[g]),
            .retire    (retire_cnt),
            .cfg       (lane_cfg[g]),
            .utilized  (lane_util[g]),
            .quiet     (lane_quiet[g])
        );
    end

    pmg_residency #(.INTERVAL(INTERVAL), .CAP_W(CAP_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en  (st_q.big && in_idle),
        .cap       (cap),
        .cap_full  (cap_full),
        .leave_big (leave_big),
        .deny_big  (deny_big)
    );

    always_comb begin
        hint_ok    = miss_hint && stall_hint && !early_load_hint;
        want_other = st_q.big ? lane_quiet[LANE_BIG]
                              : (lane_util[LANE_SMALL] && !deny_big);
        force_out  = st_q.big && leave_big;
        st_d       = st_q;
        unique case (st_q.seq)
            SEQ_IDLE:  if ((want_other && hint_ok) || force_out) st_d.seq = SEQ_FLUSH;
            SEQ_FLUSH: if (flush_done) st_d.seq = SEQ_FENCE;
            SEQ_FENCE: if (fence_done) begin
                st_d.seq = SEQ_IDLE;
                st_d.big = !st_q.big;
            end
            default:   st_d.seq = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{seq: SEQ_IDLE, big: 1'b0};
        else        st_q <= st_d;
    end

    assign big_mode    = st_q.big;
    assign switch_busy = !in_idle;
    assign flush_req   = (st_q.seq == SEQ_FLUSH);
    assign fence_req   = (st_q.seq == SEQ_FENCE);

    // R5: the mode output moves only on a completed fence
    a_r5_mode_only_after_fence: assert property (@(posedge clk) disable iff (!rst_n)
        !((st_q.seq == SEQ_FENCE) && fence_done) |=> $stable(big_mode));

    // R5: the fence step follows a completed flush
    a_r5_fence_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fence_req) |-> $past(flush_req && flush_done));

    // R4: a switch begins on a good opportunity or on an exhausted budget
    a_r4_start_reason: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req) |-> $past(force_out || (miss_hint && stall_hint && !early_load_hint)));

    // R9: the lowest core state keeps the narrow pipeline
    a_r9_floor_small: assert property (@(posedge clk) disable iff (!rst_n)
        (core_state == '0 && !big_mode && !switch_busy) |=> !switch_busy);
endmodule

// File: tb/pipe_mode_governor_test.sv
`timescale 1ns/1ps
module pipe_mode_governor_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] retire = '0;
    logic [2:0] cs = '0;
    logic       miss = 1'b0, stall = 1'b0, early = 1'b0;
    logic       fdone = 1'b0, fcdone = 1'b0;
    logic       big, busy, freq, fcreq;

    int n_checks = 0;
    int n_fail   = 0;
    int ecnt     = 0;
    int bigseen  = 0;

    always #4 clk = ~clk;

    pipe_mode_governor uut (
        .clk(clk), .rst_n(rst_n), .retire_cnt(retire), .core_state(cs),
        .miss_hint(miss), .stall_hint(stall), .early_load_hint(early),
        .flush_done(fdone), .fence_done(fcdone),
        .big_mode(big), .switch_busy(busy), .flush_req(freq), .fence_req(fcreq)
    );

    always @(posedge clk) begin
        if (!rst_n) ecnt <= 0;
        else        ecnt <= ecnt + 1;
    end

    always @(negedge clk) begin
        if (!rst_n) bigseen <= 0;
        else if (big && !busy) bigseen <= bigseen + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hints(input logic m, input logic s, input logic e);
        miss = m; stall = s; early = e;
    endtask

    task automatic do_reset(input logic [2:0] state);
        @(negedge clk);
        rst_n = 1'b0; cs = state; retire = '0; hints(0, 0, 0);
        fdone = 1'b0; fcdone = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic finish_switch(input int exp_big);
        hints(0, 0, 0);
        fdone = 1'b1; step(1); fdone = 1'b0;
        chk("R5 fence after flush", int'(fcreq), 1);
        fcdone = 1'b1; step(1); fcdone = 1'b0;
        chk("R5 mode after fence", int'(big), exp_big);
    endtask

    task automatic go_big(input logic [2:0] state);
        cs = state; retire = 3'd3; hints(0, 0, 0);
        step(8);
        hints(1, 1, 0); step(1);
        chk("R5 flush raised", int'(freq), 1);
        finish_switch(1);
    endtask

    task automatic t_reset;
        do_reset(3'd3);
        chk("R1 big_mode", int'(big), 0);
        chk("R1 switch_busy", int'(busy), 0);
        chk("R1 flush_req", int'(freq), 0);
        chk("R1 fence_req", int'(fcreq), 0);
    endtask

    task automatic t_small_promote;
        do_reset(3'd3);
        retire = 3'd3; step(7);
        retire = 3'd2; step(1);
        retire = 3'd3; step(7);
        hints(1, 1, 0); step(1);
        chk("R2 run restarted, not yet utilized", int'(freq), 0);
        step(1);
        chk("R2 utilized after 8 busy samples", int'(freq), 1);
        do_reset(3'd3);
        retire = 3'd2; hints(1, 1, 0); step(12);
        chk("R2 retire 2 never busy at 80%", int'(freq), 0);
        do_reset(3'd2);
        retire = 3'd2; step(5);
        hints(1, 1, 0); step(1);
        chk("R2 policy B before sixth sample", int'(freq), 0);
        step(1);
        chk("R2 policy B after six samples", int'(freq), 1);
    endtask

    task automatic t_opportunity;
        do_reset(3'd3);
        retire = 3'd3; step(8);
        hints(1, 0, 0); step(2);
        chk("R4 miss without stall", int'(freq), 0);
        hints(0, 1, 0); step(2);
        chk("R4 stall without miss", int'(freq), 0);
        hints(1, 1, 1); step(2);
        chk("R4 early load completion blocks", int'(freq), 0);
        hints(1, 1, 0); step(1);
        chk("R4 miss with stall starts switch", int'(freq), 1);
        chk("R5 busy during flush", int'(busy), 1);
    endtask

    task automatic t_sequence;
        do_reset(3'd4);
        retire = 3'd3; step(8);
        hints(1, 1, 0); step(1);
        chk("R5 flush raised", int'(freq), 1);
        fcdone = 1'b1; step(2); fcdone = 1'b0;
        chk("R5 early fence_done ignored", int'(freq), 1);
        chk("R5 no fence before flush done", int'(fcreq), 0);
        chk("R6 mode held while busy", int'(big), 0);
        step(2);
        chk("R6 hints ignored during flush", int'(freq), 1);
        fdone = 1'b1; step(1); fdone = 1'b0;
        chk("R5 fence step", int'(fcreq), 1);
        chk("R5 flush dropped", int'(freq), 0);
        step(2);
        chk("R5 fence held", int'(fcreq), 1);
        chk("R6 mode still held", int'(big), 0);
        fcdone = 1'b1; step(1); fcdone = 1'b0;
        chk("R5 big after fence", int'(big), 1);
        chk("R5 busy cleared", int'(busy), 0);
        hints(0, 0, 0); retire = 3'd4; step(3);
        chk("R6 single toggle", int'(big), 1);
        chk("R6 no follow-on switch", int'(busy), 0);
    endtask

    task automatic t_big_demote;
        do_reset(3'd4);
        go_big(3'd4);
        hints(1, 1, 0);
        retire = 3'd0; step(1);
        retire = 3'd1; step(1);
        retire = 3'd0; step(1);
        chk("R3 low run restarted", int'(freq), 0);
        step(1);
        chk("R3 second low sample", int'(freq), 0);
        step(1);
        chk("R3 policy A leaves big", int'(freq), 1);
        do_reset(3'd4);
        go_big(3'd4);
        cs = 3'd2; retire = 3'd2; hints(1, 1, 0);
        step(4);
        chk("R3 policy B fourth sample", int'(freq), 0);
        step(1);
        chk("R3 policy B leaves big", int'(freq), 1);
    endtask

    task automatic t_reentry;
        do_reset(3'd4);
        go_big(3'd4);
        retire = 3'd0; hints(1, 1, 0); step(3);
        chk("R3 quiet big pipe", int'(freq), 1);
        finish_switch(0);
        retire = 3'd3; step(7);
        hints(1, 1, 0); step(1);
        chk("R7 small tracker restarted", int'(freq), 0);
        step(1);
        chk("R7 small tracker full run", int'(freq), 1);
    endtask

    task automatic t_residency;
        int waited;
        logic early_flush;
        do_reset(3'd4);
        go_big(3'd4);
        cs = 3'd1; retire = 3'd3; hints(0, 0, 0);
        waited = 0;
        while (!freq && waited < 40) begin
            step(1);
            waited++;
        end
        chk("R8 forced exit without hints", int'(freq), 1);
        chk("R8 big cycles at cap 16", bigseen, 16);
        finish_switch(0);
        hints(1, 1, 0);
        early_flush = 1'b0;
        while (ecnt < 64) begin
            step(1);
            if (freq) early_flush = 1'b1;
        end
        chk("R8 re-entry denied in interval", int'(early_flush), 0);
        step(1);
        chk("R8 re-entry after interval wrap", int'(freq), 1);
    endtask

    task automatic t_floor;
        logic moved;
        do_reset(3'd0);
        retire = 3'd3; hints(1, 1, 0);
        moved = 1'b0;
        for (int i = 0; i < 40; i++) begin
            step(1);
            if (freq || big) moved = 1'b1;
        end
        chk("R9 core state 0 stays small", int'(moved), 0);
    endtask

    task automatic t_ceiling;
        logic moved;
        do_reset(3'd4);
        go_big(3'd4);
        retire = 3'd4; hints(1, 1, 0);
        moved = 1'b0;
        for (int i = 0; i < 120; i++) begin
            step(1);
            if (freq || !big) moved = 1'b1;
        end
        chk("R10 core state 4 keeps big", int'(moved), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R5: run did not complete, actual 0 expected 1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_small_promote();
        t_opportunity();
        t_sequence();
        t_big_demote();
        t_reentry();
        t_residency();
        t_floor();
        t_ceiling();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule